// File: doc/BRIEF.md
# Stereo Channel Mixer with Headphone Override

This block routes one stereo sample pair per valid strobe. A left and a right two's-complement sample enter together with `in_valid`. Each output side has its own 2-bit route code, which selects pass-through, the average of both channels, a half-difference, or the opposite channel. The result is registered, and `out_valid` flags it.

The detect/mute pin can be set by `hp_pin_is_detect` to act as a headphone-detect input. In that setting, headphones being present force the left side from an averaging route back to plain left, so the listener hears stereo. The programmed route returns once the detect clears. The right side never looks at the detect. The detect input is asynchronous and passes through two synchronizing flops. The route is fixed at the strobe for each sample, so a whole sample always follows a single setting.

Top module: `stereo_route_mixer`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `out_valid` is 0 and both outputs are 0.
- R2: Route code 00 drives each output with its own side's input sample (left to left, right to right).
- R3: Route code 01 drives an output with floor((L+R)/2), computed without overflow for all input values (e.g. 32767+32767 gives 32767, -32768+-32768 gives -32768, -1+0 gives -1).
- R4: Route code 11 drives an output with the opposite side's input (left output gets R, right output gets L).
- R5: Route code 10 gives the same average as code 01 when `diff_mix` is 0. When `diff_mix` is 1 it gives floor((own-opposite)/2): (L-R)/2 on the left and (R-L)/2 on the right.
- R6: When `hp_pin_is_detect` is 1, the synchronized detect is 1 and the left route is 01 or 10, the left output is the unmodified left input.
- R7: With `hp_pin_is_detect` at 0, `hp_detect_async` has no effect on either output. Left codes 00 and 11 are never changed by the detect. When the detect drops, the left side returns to its programmed route.
- R8: The right output always follows `route_right` and is never affected by the detect input.
- R9: A detect change made between rising edges first applies to a sample captured at the third rising edge after the change. Samples captured at the first two edges still use the old detect level.
- R10: Outputs update one clock after a strobe, with `out_valid` high for exactly that cycle. They hold their value while no strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_left | input | W | Left input sample, two's complement |
| in_right | input | W | Right input sample, two's complement |
| route_left | input | 2 | Left route code (00 own, 01 average, 10 average/half-difference, 11 opposite) |
| route_right | input | 2 | Right route code, same encoding |
| diff_mix | input | 1 | Code 10 gives half-difference instead of average |
| hp_pin_is_detect | input | 1 | Detect/mute pin configured as headphone detect |
| hp_detect_async | input | 1 | Headphone detect, asynchronous, active high |
| out_valid | output | 1 | Output sample valid |
| out_left | output | W | Left output sample |
| out_right | output | W | Right output sample |

## Verification
Every route code is applied on both sides, using ordinary values and also the positive and negative extremes and odd negative sums, where a wrong rounding or a lost carry shows up. The detect input is toggled while the pin mode is off and while it is on, and under each left code. This separates a gating error from an override that wrongly reaches codes 00/11 or the right side. Gapped strobes and a detect change placed just before a run of strobes show whether the synchronizer depth and the hold behaviour are correct.

// File: rtl/stereo_route_mixer.sv
module stereo_route_mixer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic [1:0]   route_left,
  input  logic [1:0]   route_right,
  input  logic         diff_mix,
  input  logic         hp_pin_is_detect,
  input  logic         hp_detect_async,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);

  logic hp_meta, hp_sync;
  logic hp_force;
  logic [1:0] eff_left;

  function automatic logic [W-1:0] route(input logic [1:0] code, input logic [W-1:0] own,
                                         input logic [W-1:0] opp, input logic dm);
    logic [W:0] sum, dif;
    sum = {own[W-1], own} + {opp[W-1], opp};
    dif = {own[W-1], own} - {opp[W-1], opp};
    case (code)
      2'b00:   route = own;
      2'b01:   route = sum[W:1];
      2'b10:   route = dm ? dif[W:1] : sum[W:1];
      default: route = opp;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_meta <= 1'b0;
      hp_sync <= 1'b0;
    end else begin
      hp_meta <= hp_detect_async;
      hp_sync <= hp_meta;
    end
  end

  assign hp_force = hp_pin_is_detect && hp_sync && (route_left == 2'b01 || route_left == 2'b10);
  assign eff_left = hp_force ? 2'b00 : route_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= route(eff_left, in_left, in_right, diff_mix);
        out_right <= route(route_right, in_right, in_left, diff_mix);
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid latency"); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right))) else $error("hold"); // R10
  AST_OWN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route_right == 2'b00) |=> out_right == $past(in_right)) else $error("pass"); // R2
  AST_LEFT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route_left == 2'b11) |=> out_left == $past(in_right)) else $error("swap"); // R4
  AST_HP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hp_pin_is_detect && hp_sync && route_left[0] != route_left[1])
      |=> out_left == $past(in_left)) else $error("override"); // R6
  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_meta) |-> !hp_sync) else $error("sync depth"); // R9

endmodule

// File: tb/stereo_route_mixer_tb.sv
module stereo_route_mixer_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic [1:0] route_left = 2'b00, route_right = 2'b00;
  logic diff_mix = 1'b0, hp_pin_is_detect = 1'b0, hp_detect_async = 1'b0;
  logic out_valid;
  logic [W-1:0] out_left, out_right;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_s1 = 0, m_s2 = 0;
  int exp_l = 0, exp_r = 0;
  bit exp_v = 0;

  always #2.5 clk = ~clk;

  stereo_route_mixer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .route_left(route_left), .route_right(route_right), .diff_mix(diff_mix),
    .hp_pin_is_detect(hp_pin_is_detect), .hp_detect_async(hp_detect_async),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  function automatic int mix_ref(input int code, input int own, input int opp, input bit dm);
    case (code)
      0: return own;
      1: return (own + opp) >>> 1;
      2: return dm ? ((own - opp) >>> 1) : ((own + opp) >>> 1);
      default: return opp;
    endcase
  endfunction

  task automatic compare(input string tag);
    int al, ar;
    al = $signed(out_left);
    ar = $signed(out_right);
    n_cmp++;
    if (out_valid !== exp_v || al != exp_l || ar != exp_r) begin
      n_bad++;
      $display("FAIL %s: valid=%0b L=%0d R=%0d expected valid=%0b L=%0d R=%0d",
               tag, out_valid, al, ar, exp_v, exp_l, exp_r);
    end
  endtask

  task automatic step(input string tag, input bit v, input int l, input int r,
                      input int sl, input int sr, input bit dm, input bit hm, input bit hd);
    bit force_l;
    @(negedge clk);
    in_valid = v; in_left = l[W-1:0]; in_right = r[W-1:0];
    route_left = sl[1:0]; route_right = sr[1:0];
    diff_mix = dm; hp_pin_is_detect = hm; hp_detect_async = hd;
    @(posedge clk);
    if (v) begin
      force_l = hm && m_s2 && (sl == 1 || sl == 2);
      exp_l = force_l ? l : mix_ref(sl, l, r, dm);
      exp_r = mix_ref(sr, r, l, dm);
    end
    exp_v = v;
    m_s2 = m_s1;
    m_s1 = hd;
    #1;
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    step("R1 idle after reset", 0, 5, 7, 0, 0, 0, 0, 0);

    step("R2 pass", 1, 1234, -4321, 0, 0, 0, 0, 0);
    step("R2 pass extremes", 1, 32767, -32768, 0, 0, 0, 0, 0);
    step("R3 avg", 1, 100, 301, 1, 1, 0, 0, 0);
    step("R3 avg max", 1, 32767, 32767, 1, 1, 0, 0, 0);
    step("R3 avg min", 1, -32768, -32768, 1, 1, 0, 0, 0);
    step("R3 avg floor", 1, -1, 0, 1, 1, 0, 0, 0);
    step("R4 swap", 1, 555, -777, 3, 3, 0, 0, 0);
    step("R5 code10 avg", 1, -3, 8, 2, 2, 0, 0, 0);
    step("R5 code10 diff", 1, 32767, -32768, 2, 2, 1, 0, 0);
    step("R5 code10 diff odd", 1, -5, 2, 2, 2, 1, 0, 0);
    step("R10 hold", 0, 9, 9, 0, 0, 0, 0, 0);
    step("R10 hold", 0, 1, 2, 3, 3, 0, 0, 0);

    // detect asserted with pin in mute mode: no effect
    for (int i = 0; i < 4; i++) step("R7 mode off", 1, 1000 + i, -2000, 1, 2, 0, 0, 1);
    // pin becomes detect; sync already high
    step("R6 override 01", 1, 4000, -4000, 1, 1, 0, 1, 1);
    step("R6 override 10", 1, -7, 9, 2, 2, 1, 1, 1);
    step("R7 code11 untouched", 1, 11, 22, 3, 3, 0, 1, 1);
    step("R7 code00 untouched", 1, 11, 22, 0, 1, 0, 1, 1);
    step("R8 right unaffected", 1, 300, 500, 1, 2, 1, 1, 1);
    // release detect: sync timing then restore
    for (int i = 0; i < 4; i++) step("R9 release timing", 1, 60 + i, 20, 1, 1, 0, 1, 0);
    // assert detect again, watch third edge
    for (int i = 0; i < 4; i++) step("R9 assert timing", 1, -60 - i, 20, 2, 3, 0, 1, 1);
    step("R10 gap", 0, 0, 0, 1, 1, 0, 1, 1);
    step("R6 after gap", 1, 17, -17, 1, 0, 0, 1, 1);
    step("R7 restore", 1, 17, -17, 1, 0, 0, 1, 0);
    step("R7 restore", 1, 17, -17, 1, 0, 0, 1, 0);
    step("R7 restored", 1, 17, -16, 1, 0, 0, 1, 0);

    for (int i = 0; i < 64; i++)
      step("R3 R5 sweep", (i % 5) != 0, (i * 1237) % 65536 - 32768, 32767 - (i * 911) % 65536,
           i % 4, (i / 4) % 4, i[3], i[4], i[2]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule